// File: doc/BRIEF.md
# Serial Command Front-End for a Small Nonvolatile Store

This block is the device-side front end of a four-wire serial memory link (chip select, serial clock, data in, data out). It runs on a fast system clock. It brings the three serial inputs and the organization select into that domain through a two-flop synchronizer, and it finds serial-clock rising edges in the synchronized copy. A framing state machine waits for a start bit, then collects a four-bit opcode, an address whose length depends on the organization, and any write data. It then decodes one of six instructions.

A read returns data from a register array held inside the block. The data goes out on a serial output: a single zero bit, then the data word MSB first. At the end of the word, or when chip select falls, the output enable is dropped. Programming instructions (single write, erase-all, write-all) are passed to an external program-cycle controller. Each one is a one-cycle request carrying a kind, an address and data. The block stays busy until the controller acknowledges, and it applies the change to its array at that acknowledge. A write-enable latch, set and cleared by two of the instructions, gates every programming request.

The framing machine has six states: `FS_IDLE` waits for the start bit, `FS_OPC` gathers the opcode, `FS_ADR` gathers the address, `FS_DAT` gathers write data, `FS_RDO` shifts out read data and `FS_END` ignores everything. The transitions are:
- Chip select low forces `FS_IDLE` from any state.
- `FS_IDLE` goes to `FS_OPC` when DI is high at a serial-clock rise and busy is low.
- `FS_OPC` goes to `FS_ADR` after four bits.
- After the last address bit, `FS_ADR` goes to `FS_RDO` for a read, to `FS_DAT` for write or write-all, and to `FS_END` for every other opcode.
- `FS_DAT` goes to `FS_END` after the last data bit.
- `FS_RDO` goes to `FS_END` on the rise after the last data bit.

Top module: `mw_slave_top`

## Requirements
- R1: A frame begins at the first serial-clock rise that sees both chip select and DI high. Rises with DI low before that point have no effect.
- R2: The opcode is the four bits after the start bit, MSB first:
  - 10xx is read and 01xx is write.
  - 0011 enables programming and 0000 disables it.
  - 0010 is erase-all and 0001 is write-all.
- R3: The organization input sets the field lengths. With org=1 the address is 6 bits and the data is 16 bits. With org=0 the address is 7 bits and the data is 8 bits, both MSB first. A frame whose bit count is not complete when chip select falls does nothing.
- R4: On read, DO is enabled and driven 0 at the rise that captures the last address bit. Each later rise then drives one data bit, MSB first.
- R5: With org=0, byte address a reads word a[6:1]. The byte is the upper half of the word when a[0]=1 and the lower half when a[0]=0.
- R6: DO is disabled at the rise after the last data bit, or as soon as chip select falls, whichever comes first. DO is disabled at every other time.
- R7: Once a frame is complete, further clocks and DI are ignored until chip select goes low and high again.
- R8: After reset, and after the disable instruction, write, erase-all and write-all raise no request. They do so only after the enable instruction.
- R9: An enabled programming instruction raises prog_req for exactly one cycle and sets busy. The request carries prog_kind (01 write, 10 erase-all, 11 write-all), prog_addr (the address field) and prog_data (the data right-aligned, or zero for erase-all).
- R10: While busy is high, a start bit is refused and the frame that follows has no effect.
- R11: prog_ack while busy clears busy and updates the array:
  - A write changes the addressed word, or the addressed byte when org=0.
  - Erase-all sets every bit to 1.
  - Write-all stores the data in every word; with org=0 the byte is placed in both halves.
- R12: After reset, DO is disabled, busy and prog_req are low, and every array bit is 1.
- R13: Opcodes 11xx complete their address field and then do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_in | input | 1 | Serial chip select, active high |
| sclk_in | input | 1 | Serial clock, sampled on its rising edge |
| di_in | input | 1 | Serial data in |
| org_in | input | 1 | Organization: 1 = 16-bit words, 0 = bytes |
| do_out | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for DO; the pad is high-Z when this is low |
| prog_ack | input | 1 | Program-cycle controller done |
| prog_req | output | 1 | One-cycle program request |
| prog_kind | output | 2 | 01 write, 10 erase-all, 11 write-all |
| prog_addr | output | 7 | Address field of the request |
| prog_data | output | 16 | Data of the request, right-aligned |
| busy | output | 1 | High from a request until its acknowledge |

## Verification
The hardest case to reach from the ports is a start bit arriving while a program cycle is still pending. The bench reaches it because it drives the acknowledge itself. It issues an enabled write, holds prog_ack low, and clocks a full read frame while busy is high. It then expects DO to stay disabled throughout and the later readback to show only the acknowledged write. Two other cases need careful timing. In one, chip select is dropped in the middle of a read word. In the other, a complete instruction is followed by a bit pattern that would form a valid read if it were not ignored.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPC,
        FS_ADR,
        FS_DAT,
        FS_RDO,
        FS_END
    } fstate_t;

    typedef enum logic [2:0] {
        CM_NONE,
        CM_WRITE,
        CM_ERAL,
        CM_WRAL,
        CM_EWEN,
        CM_EWDS
    } cmd_t;

    localparam logic [1:0] PK_WRITE = 2'b01;
    localparam logic [1:0] PK_ERAL  = 2'b10;
    localparam logic [1:0] PK_WRAL  = 2'b11;

    localparam logic [3:0] OP_EWEN = 4'b0011;
    localparam logic [3:0] OP_EWDS = 4'b0000;
    localparam logic [3:0] OP_ERAL = 4'b0010;
    localparam logic [3:0] OP_WRAL = 4'b0001;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mw_frame.sv
module mw_frame
    import mw_pkg::*;
#(
    parameter int OPW = 4,
    parameter int AB  = 7,
    parameter int DW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          sclk_rise,
    input  logic          di,
    input  logic          org,
    input  logic          busy,
    input  logic [DW-1:0] rd_data,
    output logic [AB-1:0] rd_addr,
    output logic          cmd_valid,
    output cmd_t          cmd,
    output logic [AB-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data,
    output logic          do_val,
    output logic          do_oe
);

    localparam int CW = $clog2(DW + 1);
    localparam int IW = $clog2(DW);
    localparam int BW = DW / 2;
    localparam logic [CW-1:0] OPC_LAST = CW'(OPW - 1);

    fstate_t          state_q, nxt;
    logic [CW-1:0]    cnt_q;
    logic [OPW-1:0]   op_q;
    logic [AB-1:0]    addr_q;
    logic [DW-2:0]    data_q;

    logic [CW-1:0]    aw_last, dw_last, dw_need;
    logic [AB-1:0]    addr_nxt;
    logic [IW-1:0]    bit_idx;
    logic             op_read, op_write, op_wral, op_single;

    assign aw_last  = org ? CW'(AB - 2) : CW'(AB - 1);
    assign dw_last  = org ? CW'(DW - 1) : CW'(BW - 1);
    assign dw_need  = org ? CW'(DW)     : CW'(BW);
    assign addr_nxt = org ? {1'b0, addr_q[AB-3:0], di} : {addr_q[AB-2:0], di};
    assign bit_idx  = IW'(dw_last - cnt_q);

    assign op_read   = (op_q[OPW-1:OPW-2] == 2'b10);
    assign op_write  = (op_q[OPW-1:OPW-2] == 2'b01);
    assign op_wral   = (op_q == OP_WRAL);
    assign op_single = (op_q == OP_EWEN) || (op_q == OP_EWDS) || (op_q == OP_ERAL);

    assign rd_addr = addr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state_q;
        if (!cs) begin
            nxt = FS_IDLE;
        end else if (sclk_rise) begin
            unique case (state_q)
                FS_IDLE: if (di && !busy) nxt = FS_OPC;
                FS_OPC:  if (cnt_q == OPC_LAST) nxt = FS_ADR;
                FS_ADR: begin
                    if (cnt_q == aw_last) begin
                        if (op_read)                  nxt = FS_RDO;
                        else if (op_write || op_wral) nxt = FS_DAT;
                        else                          nxt = FS_END;
                    end
                end
                FS_DAT:  if (cnt_q == dw_last) nxt = FS_END;
                FS_RDO:  if (cnt_q == dw_need) nxt = FS_END;
                FS_END:  nxt = FS_END;
                default: nxt = FS_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            op_q      <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            cmd_valid <= 1'b0;
            cmd       <= CM_NONE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            do_val    <= 1'b0;
            do_oe     <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (!cs) begin
                cnt_q  <= '0;
                do_oe  <= 1'b0;
                do_val <= 1'b0;
            end else if (sclk_rise) begin
                unique case (state_q)
                    FS_IDLE: cnt_q <= '0;
                    FS_OPC: begin
                        op_q  <= {op_q[OPW-2:0], di};
                        cnt_q <= (cnt_q == OPC_LAST) ? '0 : cnt_q + CW'(1);
                    end
                    FS_ADR: begin
                        addr_q <= addr_nxt;
                        if (cnt_q == aw_last) begin
                            cnt_q <= '0;
                            if (op_read) begin
                                do_oe  <= 1'b1;
                                do_val <= 1'b0;
                            end else if (op_single) begin
                                cmd_valid <= 1'b1;
                                cmd_addr  <= addr_nxt;
                                cmd_data  <= '0;
                                if (op_q == OP_EWEN)      cmd <= CM_EWEN;
                                else if (op_q == OP_EWDS) cmd <= CM_EWDS;
                                else                      cmd <= CM_ERAL;
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    FS_DAT: begin
                        data_q <= {data_q[DW-3:0], di};
                        if (cnt_q == dw_last) begin
                            cnt_q     <= '0;
                            cmd_valid <= 1'b1;
                            cmd       <= op_wral ? CM_WRAL : CM_WRITE;
                            cmd_addr  <= addr_q;
                            cmd_data  <= org ? {data_q[DW-2:0], di}
                                             : {{BW{1'b0}}, data_q[BW-2:0], di};
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    FS_RDO: begin
                        if (cnt_q < dw_need) begin
                            do_val <= rd_data[bit_idx];
                            cnt_q  <= cnt_q + CW'(1);
                        end else begin
                            do_oe  <= 1'b0;
                            do_val <= 1'b0;
                        end
                    end
                    FS_END: cnt_q <= cnt_q;
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    // R6
    oe_drops_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !do_oe);

    // R4
    oe_only_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_oe |-> (state_q == FS_RDO));

    // R10
    start_refused_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_IDLE && sclk_rise && busy) |=> (state_q == FS_IDLE));

    // R7
    end_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_END && cs) |=> (state_q == FS_END));

    // R3
    cmd_at_full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (state_q == FS_END));

endmodule

// File: rtl/mw_store.sv
module mw_store
    import mw_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int DW    = 16,
    parameter int AB    = $clog2(WORDS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          org,
    input  logic          cmd_valid,
    input  cmd_t          cmd,
    input  logic [AB-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic [AB-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          prog_ack,
    output logic          prog_req,
    output logic [1:0]    prog_kind,
    output logic [AB-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          busy
);

    localparam int WA = $clog2(WORDS);
    localparam int BW = DW / 2;

    logic [DW-1:0] mem [WORDS];
    logic          wen_q;
    logic          p_org;
    logic [WA-1:0] rw_idx;
    logic [DW-1:0] rd_word;

    assign rw_idx  = org ? rd_addr[WA-1:0] : rd_addr[WA:1];
    assign rd_word = mem[rw_idx];
    assign rd_data = org ? rd_word
                         : {{BW{1'b0}}, (rd_addr[0] ? rd_word[DW-1:BW] : rd_word[BW-1:0])};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
            wen_q     <= 1'b0;
            busy      <= 1'b0;
            prog_req  <= 1'b0;
            prog_kind <= '0;
            prog_addr <= '0;
            prog_data <= '0;
            p_org     <= 1'b0;
        end else begin
            prog_req <= 1'b0;
            if (cmd_valid && !busy) begin
                unique case (cmd)
                    CM_EWEN: wen_q <= 1'b1;
                    CM_EWDS: wen_q <= 1'b0;
                    CM_WRITE, CM_ERAL, CM_WRAL: begin
                        if (wen_q) begin
                            prog_req  <= 1'b1;
                            busy      <= 1'b1;
                            prog_addr <= cmd_addr;
                            prog_data <= cmd_data;
                            p_org     <= org;
                            prog_kind <= (cmd == CM_WRITE) ? PK_WRITE :
                                         (cmd == CM_ERAL)  ? PK_ERAL  : PK_WRAL;
                        end
                    end
                    default: wen_q <= wen_q;
                endcase
            end
            if (prog_ack && busy) begin
                busy <= 1'b0;
                for (int w = 0; w < WORDS; w++) begin
                    unique case (prog_kind)
                        PK_ERAL: mem[w] <= '1;
                        PK_WRAL: mem[w] <= p_org ? prog_data
                                                 : {prog_data[BW-1:0], prog_data[BW-1:0]};
                        PK_WRITE: begin
                            if (p_org && WA'(w) == prog_addr[WA-1:0]) begin
                                mem[w] <= prog_data;
                            end else if (!p_org && WA'(w) == prog_addr[WA:1]) begin
                                if (prog_addr[0]) mem[w][DW-1:BW] <= prog_data[BW-1:0];
                                else              mem[w][BW-1:0]  <= prog_data[BW-1:0];
                            end
                        end
                        default: mem[w] <= mem[w];
                    endcase
                end
            end
        end
    end

    // R9
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R9
    req_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> busy);

    // R8
    req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wen_q));

    // R11
    ack_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_ack && busy) |=> !busy);

endmodule

// File: rtl/mw_slave_top.sv
module mw_slave_top
    import mw_pkg::*;
#(
    parameter int WORDS     = 64,
    parameter int DW        = 16,
    parameter int OPW       = 4,
    parameter int SYNC_STGS = 2,
    parameter int AB        = $clog2(WORDS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_in,
    input  logic          sclk_in,
    input  logic          di_in,
    input  logic          org_in,
    output logic          do_out,
    output logic          do_oe,
    input  logic          prog_ack,
    output logic          prog_req,
    output logic [1:0]    prog_kind,
    output logic [AB-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          busy
);

    logic [3:0]    sync_q;
    logic          cs_s, sclk_s, di_s, org_s;
    logic          sclk_prev, sclk_rise;
    logic          cmd_valid;
    cmd_t          cmd;
    logic [AB-1:0] cmd_addr, rd_addr;
    logic [DW-1:0] cmd_data, rd_data;

    mw_sync #(.W(4), .STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({org_in, cs_in, sclk_in, di_in}),
        .q     (sync_q)
    );

    assign {org_s, cs_s, sclk_s, di_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign sclk_rise = sclk_s && !sclk_prev;

    mw_frame #(.OPW(OPW), .AB(AB), .DW(DW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs_s),
        .sclk_rise (sclk_rise),
        .di        (di_s),
        .org       (org_s),
        .busy      (busy),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .do_val    (do_out),
        .do_oe     (do_oe)
    );

    mw_store #(.WORDS(WORDS), .DW(DW), .AB(AB)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .org       (org_s),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .prog_ack  (prog_ack),
        .prog_req  (prog_req),
        .prog_kind (prog_kind),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .busy      (busy)
    );

endmodule

// File: tb/sim_mw_slave_top.sv
module sim_mw_slave_top;

    localparam int HP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1, ack = 1'b0;
    logic        do_out, do_oe, prog_req, busy;
    logic [1:0]  prog_kind;
    logic [6:0]  prog_addr;
    logic [15:0] prog_data;

    int nchk = 0;
    int nbad = 0;

    typedef struct { logic oe; logic v; string tag; } dexp_t;
    typedef struct { logic [1:0] k; logic [6:0] a; logic [15:0] d; string tag; } pexp_t;
    dexp_t dq[$];
    pexp_t pq[$];
    event  smp;

    always #5 clk = ~clk;

    mw_slave_top u0 (
        .clk(clk), .rst_n(rst_n), .cs_in(cs), .sclk_in(sclk), .di_in(di), .org_in(org),
        .do_out(do_out), .do_oe(do_oe), .prog_ack(ack), .prog_req(prog_req),
        .prog_kind(prog_kind), .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy)
    );

    // DO scoreboard monitor
    always begin
        @(smp);
        if (dq.size() == 0) begin
            nbad++;
            $display("FAIL scoreboard: DO sample with empty queue, actual %b/%b expected none", do_oe, do_out);
        end else begin
            dexp_t e;
            e = dq.pop_front();
            nchk++;
            if (do_oe !== e.oe || (e.oe && do_out !== e.v)) begin
                nbad++;
                $display("FAIL %s: do_oe/do_out actual %b/%b expected %b/%b", e.tag, do_oe, do_out, e.oe, e.v);
            end
        end
    end

    // request scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && prog_req) begin
            if (pq.size() == 0) begin
                nbad++;
                $display("FAIL R8: unexpected request actual kind=%0d addr=%0d data=%h expected none",
                         prog_kind, prog_addr, prog_data);
            end else begin
                pexp_t p;
                p = pq.pop_front();
                nchk++;
                if (prog_kind !== p.k || prog_addr !== p.a || prog_data !== p.d) begin
                    nbad++;
                    $display("FAIL %s: request actual %0d/%h/%h expected %0d/%h/%h",
                             p.tag, prog_kind, prog_addr, prog_data, p.k, p.a, p.d);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic d, input logic eoe, input logic ev, input string tag);
        dq.push_back('{eoe, ev, tag});
        di = d;
        repeat (HP) @(posedge clk);
        #1 sclk = 1'b1;
        repeat (HP) @(posedge clk);
        #1;
        -> smp;
        sclk = 1'b0;
    endtask

    task automatic cs_up();
        cs = 1'b1;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic cs_down();
        sclk = 1'b0;
        cs = 1'b0;
        di = 1'b0;
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic set_org(input logic o);
        org = o;
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic read_frame(input logic [6:0] a, input logic [15:0] d, input bit live,
                              input int cut, input int pre0, input string tag);
        int na, nd;
        na = org ? 6 : 7;
        nd = org ? 16 : 8;
        cs_up();
        for (int i = 0; i < pre0; i++) tick(1'b0, 1'b0, 1'b0, tag);
        tick(1'b1, 1'b0, 1'b0, tag);
        tick(1'b1, 1'b0, 1'b0, tag);
        tick(1'b0, 1'b0, 1'b0, tag);
        tick(1'b0, 1'b0, 1'b0, tag);
        tick(1'b0, 1'b0, 1'b0, tag);
        for (int i = na - 1; i >= 0; i--) tick(a[i], live && (i == 0), 1'b0, tag);
        for (int i = 0; i < nd && i < cut; i++) tick(1'b0, live, d[nd-1-i], tag);
        if (cut >= nd) tick(1'b0, 1'b0, 1'b0, tag);
        cs_down();
        chk(do_oe == 1'b0, "R6 after cs low", {31'd0, do_oe}, 32'd0);
    endtask

    task automatic cmd_frame(input logic [3:0] op, input logic [6:0] a, input logic [15:0] d,
                             input int nd, input logic [31:0] ext, input int nx, input string tag);
        int na;
        na = org ? 6 : 7;
        cs_up();
        tick(1'b1, 1'b0, 1'b0, tag);
        for (int i = 3; i >= 0; i--) tick(op[i], 1'b0, 1'b0, tag);
        for (int i = na - 1; i >= 0; i--) tick(a[i], 1'b0, 1'b0, tag);
        for (int i = 0; i < nd; i++) tick(d[nd-1-i], 1'b0, 1'b0, tag);
        for (int i = 0; i < nx; i++) tick(ext[31-i], 1'b0, 1'b0, tag);
        cs_down();
    endtask

    task automatic give_ack();
        @(posedge clk); #1 ack = 1'b1;
        @(posedge clk); #1 ack = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        // R12 reset state
        chk(do_oe == 1'b0, "R12 do_oe", {31'd0, do_oe}, 32'd0);
        chk(busy == 1'b0, "R12 busy", {31'd0, busy}, 32'd0);
        chk(prog_req == 1'b0, "R12 prog_req", {31'd0, prog_req}, 32'd0);

        // R1 leading zero clocks, R12 erased array
        read_frame(7'd5, 16'hFFFF, 1'b1, 16, 3, "R1/R12 read erased");

        // R8 write before enable
        cmd_frame(4'b0100, 7'd5, 16'h1111, 16, 32'd0, 0, "R8 write disabled");
        chk(busy == 1'b0, "R8 busy stays low", {31'd0, busy}, 32'd0);
        read_frame(7'd5, 16'hFFFF, 1'b1, 16, 0, "R8 unchanged");

        // R2 enable, R9 write request
        cmd_frame(4'b0011, 7'd0, 16'd0, 0, 32'd0, 0, "R2 enable");
        pq.push_back('{2'b01, 7'd5, 16'hA55A, "R9 write req"});
        cmd_frame(4'b0100, 7'd5, 16'hA55A, 16, 32'd0, 0, "R9 write frame");
        chk(busy == 1'b1, "R9 busy set", {31'd0, busy}, 32'd1);
        give_ack();
        chk(busy == 1'b0, "R11 busy cleared", {31'd0, busy}, 32'd0);
        read_frame(7'd5, 16'hA55A, 1'b1, 16, 0, "R4 word read");

        // R5 byte view
        set_org(1'b0);
        read_frame(7'd11, 16'h00A5, 1'b1, 8, 0, "R5 upper byte");
        read_frame(7'd10, 16'h005A, 1'b1, 8, 0, "R5 lower byte");

        // R10 start refused while busy
        pq.push_back('{2'b01, 7'd20, 16'h003C, "R3 byte write req"});
        cmd_frame(4'b0110, 7'd20, 16'h003C, 8, 32'd0, 0, "R3 byte write frame");
        chk(busy == 1'b1, "R10 busy pending", {31'd0, busy}, 32'd1);
        read_frame(7'd20, 16'h0000, 1'b0, 8, 0, "R10 refused read");
        chk(busy == 1'b1, "R10 busy held", {31'd0, busy}, 32'd1);
        give_ack();
        read_frame(7'd20, 16'h003C, 1'b1, 8, 0, "R11 byte written");
        read_frame(7'd21, 16'h00FF, 1'b1, 8, 0, "R11 other byte kept");

        // R6 chip select falls mid word
        set_org(1'b1);
        read_frame(7'd5, 16'hA55A, 1'b1, 5, 0, "R6 early cs");

        // R7 a full read pattern after a complete frame is ignored
        cmd_frame(4'b0011, 7'd0, 16'd0, 0, 32'b1100_0000_0101_0000_0000_0000_0000_0000, 28,
                  "R7 ignored tail");
        chk(busy == 1'b0, "R7 no request", {31'd0, busy}, 32'd0);

        // R13 unused opcode
        cmd_frame(4'b1101, 7'd3, 16'd0, 0, 32'd0, 0, "R13 unused op");
        chk(busy == 1'b0, "R13 no request", {31'd0, busy}, 32'd0);

        // R11 write, erase-all, write-all
        pq.push_back('{2'b01, 7'd63, 16'h0F0F, "R9 top addr req"});
        cmd_frame(4'b0100, 7'd63, 16'h0F0F, 16, 32'd0, 0, "R9 top addr frame");
        give_ack();
        read_frame(7'd63, 16'h0F0F, 1'b1, 16, 0, "R11 top word");
        pq.push_back('{2'b10, 7'd0, 16'h0000, "R9 erase-all req"});
        cmd_frame(4'b0010, 7'd0, 16'd0, 0, 32'd0, 0, "R2 erase-all frame");
        give_ack();
        read_frame(7'd5, 16'hFFFF, 1'b1, 16, 0, "R11 erased");
        pq.push_back('{2'b11, 7'd0, 16'h1234, "R9 write-all req"});
        cmd_frame(4'b0001, 7'd0, 16'h1234, 16, 32'd0, 0, "R2 write-all frame");
        give_ack();
        read_frame(7'd63, 16'h1234, 1'b1, 16, 0, "R11 write-all word");

        set_org(1'b0);
        pq.push_back('{2'b11, 7'd0, 16'h005A, "R9 byte write-all req"});
        cmd_frame(4'b0001, 7'd0, 16'h005A, 8, 32'd0, 0, "R3 byte write-all frame");
        give_ack();
        read_frame(7'd127, 16'h005A, 1'b1, 8, 0, "R11 last byte");
        read_frame(7'd0, 16'h005A, 1'b1, 8, 0, "R11 first byte");

        // R3 incomplete frame does nothing
        set_org(1'b1);
        cmd_frame(4'b0100, 7'd9, 16'h7777, 15, 32'd0, 0, "R3 short write");
        chk(busy == 1'b0, "R3 short no request", {31'd0, busy}, 32'd0);
        read_frame(7'd9, 16'h5A5A, 1'b1, 16, 0, "R3 unchanged");

        // R8 disable blocks again
        cmd_frame(4'b0000, 7'd0, 16'd0, 0, 32'd0, 0, "R8 disable");
        cmd_frame(4'b0111, 7'd9, 16'h0001, 16, 32'd0, 0, "R8 write after disable");
        chk(busy == 1'b0, "R8 no request", {31'd0, busy}, 32'd0);
        read_frame(7'd9, 16'h5A5A, 1'b1, 16, 0, "R8 still unchanged");

        repeat (20) @(posedge clk);
        chk(pq.size() == 0, "R9 all requests seen", pq.size(), 32'd0);
        chk(dq.size() == 0, "R4 all DO samples used", dq.size(), 32'd0);
        finish_run();
    end

endmodule